// File: doc/BRIEF.md
# Glitchless Clock Output Gate with Power-Down Qualification

This block sits between a clock divider and an output pad. It passes the divided clock to the pad only when three things hold: the output-enable input is high, the oscillator is running, and the oscillator has run long enough to settle. Everything is registered on the master clock. The divided clock arrives as a level that is sampled in that same clock domain. The enable gate opens and closes only while the divided clock is low. As a result, the pad never shows a shortened high pulse. The time from an enable to the first rising edge at the pad is also fixed for a given divider phase.

The run input is active high. When it drops, that is a request to power down, and the block only acts on it after the request has lasted long enough. The request must persist for a parameterised number of master-clock cycles, and the divided clock must rise at least a parameterised number of times during that interval. Only then does the oscillator-run output fall. When the run input goes high again, the oscillator restarts. The settling count then starts over from zero.

A pad-mode input chooses how an idle pad behaves. It either drives the pad low or releases it to high impedance. The output-enable input only gates the pad. It never stops the oscillator.

Top module: `clk_out_gate`

## Requirements
- R1: While reset is asserted and on the first cycle after it: osc_run is 1 and pad_data is 0. pad_drive equals idle_drive_low.
- R2: After reset, or after osc_run rises, pad_data stays 0 until osc_run has been high for SETTLE_CYC (default 512) consecutive master-clock edges.
- R3: While out_en is 0, no new pad_data pulse appears. osc_run stays 1 as long as pwr_on is 1.
- R4: A low pwr_on is ignored (osc_run stays 1) in either of two cases. The first is that it returns high before DEGLITCH_CYC (default 2000) consecutive low cycles. The second is that fewer than MIN_EDGES (default 2) rising edges of div_clk are sampled while it is low.
- R5: Once pwr_on has been low for DEGLITCH_CYC cycles and MIN_EDGES div_clk rises have been seen, osc_run falls on the next edge. pad_data is 0 from that cycle onward.
- R6: osc_run returns to 1 one edge after pwr_on is sampled high. The settling count then restarts from zero, so R2 applies again.
- R7: While the gate is closed or osc_run is 0, pad_data is 0. pad_drive is 1 when idle_drive_low is 1 (pad driven low) and 0 when it is 0 (high impedance).
- R8: The gate opens only on an edge where div_clk was sampled low. The first pad pulse is therefore a complete div_clk high phase.
- R9: The gate closes on out_en only on an edge where div_clk was sampled low. Every pad_data high pulse that ends while osc_run is 1 lasts exactly one div_clk high phase.
- R10: With the gate open and osc_run at 1, pad_data follows div_clk in the same cycle and pad_drive is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_clk | input | 1 | Divided clock level, synchronous to clk |
| out_en | input | 1 | Output enable, high passes the clock |
| pwr_on | input | 1 | High keeps the oscillator running, low requests power-down |
| idle_drive_low | input | 1 | Idle pad mode: 1 drives low, 0 releases to high impedance |
| pad_data | output | 1 | Data value toward the pad |
| pad_drive | output | 1 | Pad driver enable |
| osc_run | output | 1 | Oscillator run control |

## Verification
All inputs change on the falling clock edge. Outputs are sampled one nanosecond after the rising edge. By then osc_run and the gate state reflect that edge, and pad_data and pad_drive have settled through their combinational paths from the registered gate and the current div_clk level. osc_run is due one edge after pwr_on goes high or the qualification completes. A gate change is due on the first edge at which div_clk is sampled low. Output pulses may reappear only after SETTLE_CYC edges with osc_run high. A behavioural model in the bench advances on the same edge and is compared on every sample. Directed windows count pad pulses and measure their lengths against the div_clk half period.

// File: rtl/coe_pkg.sv
package coe_pkg;

   // counter width able to hold 0..maxval, never narrower than one bit
   function automatic int cnt_width(input int unsigned maxval);
      return (maxval < 2) ? 1 : $clog2(maxval + 1);
   endfunction

   typedef struct packed {
      logic data;
      logic drive;
   } pad_t;

endpackage

// File: rtl/coe_pdn_qual.sv
module coe_pdn_qual #(
   parameter int unsigned DEGLITCH_CYC = 2000,
   parameter int unsigned MIN_EDGES    = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwr_on,
   input  logic div_clk,
   output logic run
);
   localparam int LW = coe_pkg::cnt_width(DEGLITCH_CYC);

   if (DEGLITCH_CYC < 1) begin : g_bad_deglitch
      $error("DEGLITCH_CYC must be at least 1");
   end

   logic [LW-1:0] low_cnt;
   logic          low_done;
   logic          edges_done;
   logic          qual;
   logic          run_q;

   assign low_done = (low_cnt == LW'(DEGLITCH_CYC));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_cnt <= '0;
      end else if (pwr_on) begin
         low_cnt <= '0;
      end else if (!low_done) begin
         low_cnt <= low_cnt + 1'b1;
      end
   end

   // divided-clock period qualification: a variant per MIN_EDGES
   if (MIN_EDGES == 0) begin : g_no_edges
      assign edges_done = 1'b1;
   end else begin : g_edges
      localparam int EW = coe_pkg::cnt_width(MIN_EDGES);
      logic [EW-1:0] edge_cnt;
      logic          div_prev;
      logic          div_rise;

      assign div_rise   = div_clk & ~div_prev;
      assign edges_done = (edge_cnt == EW'(MIN_EDGES));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            edge_cnt <= '0;
            div_prev <= 1'b0;
         end else begin
            div_prev <= div_clk;
            if (pwr_on) begin
               edge_cnt <= '0;
            end else if (div_rise && !edges_done) begin
               edge_cnt <= edge_cnt + 1'b1;
            end
         end
      end
   end

   assign qual = low_done & edges_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b1;
      end else if (pwr_on) begin
         run_q <= 1'b1;
      end else if (qual) begin
         run_q <= 1'b0;
      end
   end

   assign run = run_q;

   AST_DROP_NEEDS_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(run_q) |-> $past(qual) && !$past(pwr_on)); // R5
   AST_RISE_NEEDS_PWR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run_q) |-> $past(pwr_on)); // R6
   AST_SHORT_LOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && !low_done) |=> run_q); // R4

endmodule

// File: rtl/coe_settle_cnt.sv
module coe_settle_cnt #(
   parameter int unsigned SETTLE_CYC = 512
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic done
);
   localparam int SW = coe_pkg::cnt_width(SETTLE_CYC);

   if (SETTLE_CYC < 1) begin : g_bad_settle
      $error("SETTLE_CYC must be at least 1");
   end

   logic [SW-1:0] cnt;

   assign done = (cnt == SW'(SETTLE_CYC));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!run) begin
         cnt <= '0;
      end else if (!done) begin
         cnt <= cnt + 1'b1;
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= SW'(SETTLE_CYC)); // R2
   AST_SETTLE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run) |-> (cnt == '0)); // R6

endmodule

// File: rtl/coe_pad_gate.sv
module coe_pad_gate (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          div_clk,
   input  logic          run,
   input  logic          want,
   input  logic          idle_drive_low,
   output logic          gate,
   output coe_pkg::pad_t pad
);
   logic gate_q;
   logic active;

   // gate moves only while the divided clock is low
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gate_q <= 1'b0;
      end else if (!run) begin
         gate_q <= 1'b0;
      end else if (!div_clk) begin
         gate_q <= want;
      end
   end

   assign active    = gate_q & run;
   assign pad.data  = div_clk & active;
   assign pad.drive = active | idle_drive_low;
   assign gate      = gate_q;

   AST_GATE_MOVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(run) && !$stable(gate_q)) |-> !$past(div_clk)); // R8
   AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(run) |-> !gate_q); // R5

endmodule

// File: rtl/clk_out_gate.sv
module clk_out_gate #(
   parameter int unsigned SETTLE_CYC   = 512,
   parameter int unsigned DEGLITCH_CYC = 2000,
   parameter int unsigned MIN_EDGES    = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic div_clk,
   input  logic out_en,
   input  logic pwr_on,
   input  logic idle_drive_low,
   output logic pad_data,
   output logic pad_drive,
   output logic osc_run
);
   logic          run;
   logic          settled;
   logic          want;
   logic          gate;
   coe_pkg::pad_t pad;

   coe_pdn_qual #(
      .DEGLITCH_CYC(DEGLITCH_CYC),
      .MIN_EDGES   (MIN_EDGES)
   ) u_qual (
      .clk    (clk),
      .rst_n  (rst_n),
      .pwr_on (pwr_on),
      .div_clk(div_clk),
      .run    (run)
   );

   coe_settle_cnt #(
      .SETTLE_CYC(SETTLE_CYC)
   ) u_settle (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (run),
      .done (settled)
   );

   assign want = settled & out_en;

   coe_pad_gate u_gate (
      .clk           (clk),
      .rst_n         (rst_n),
      .div_clk       (div_clk),
      .run           (run),
      .want          (want),
      .idle_drive_low(idle_drive_low),
      .gate          (gate),
      .pad           (pad)
   );

   assign pad_data  = pad.data;
   assign pad_drive = pad.drive;
   assign osc_run   = run;

   AST_OUT_AFTER_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
      gate |-> settled); // R2
   AST_OE_KEEPS_OSC: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(pwr_on) && $past(osc_run)) |-> osc_run); // R3

endmodule

// File: tb/tb_clk_out_gate.sv
`timescale 1ns/1ps
module tb_clk_out_gate;
   localparam int SETTLE = 512;
   localparam int DG     = 2000;
   localparam int EDGES  = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic div_clk = 1'b0;
   logic out_en = 1'b1;
   logic pwr_on = 1'b1;
   logic idle_drive_low = 1'b1;
   logic pad_data, pad_drive, osc_run;

   int errors = 0;
   int checks = 0;
   int hp = 3;
   string ph = "R1";

   always #2.5 clk = ~clk;

   clk_out_gate #(.SETTLE_CYC(SETTLE), .DEGLITCH_CYC(DG), .MIN_EDGES(EDGES)) dut (
      .clk(clk), .rst_n(rst_n), .div_clk(div_clk), .out_en(out_en),
      .pwr_on(pwr_on), .idle_drive_low(idle_drive_low),
      .pad_data(pad_data), .pad_drive(pad_drive), .osc_run(osc_run));

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   // divided-clock source: each level lasts hp cycles, held low while stopped
   initial begin
      int dcnt = 0;
      forever begin
         @(negedge clk);
         if (!osc_run) begin
            div_clk = 1'b0;
            dcnt = 0;
         end else if (dcnt >= hp - 1) begin
            div_clk = ~div_clk;
            dcnt = 0;
         end else begin
            dcnt++;
         end
      end
   end

   // behavioural reference
   int m_low = 0, m_edges = 0, m_settle = 0;
   bit m_run = 1'b1, m_gate = 1'b0, m_prev = 1'b0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_low = 0; m_edges = 0; m_settle = 0;
         m_run = 1'b1; m_gate = 1'b0; m_prev = 1'b0;
      end else begin
         bit qual, was_run, ready;
         qual    = (m_low >= DG) && (m_edges >= EDGES);
         was_run = m_run;
         ready   = (m_settle >= SETTLE);
         if (pwr_on) begin
            m_low = 0; m_edges = 0; m_run = 1'b1;
         end else begin
            if (m_low < DG) m_low++;
            if (div_clk && !m_prev && m_edges < EDGES) m_edges++;
            if (qual) m_run = 1'b0;
         end
         if (!was_run) m_settle = 0;
         else if (m_settle < SETTLE) m_settle++;
         if (!was_run) m_gate = 1'b0;
         else if (!div_clk) m_gate = ready && out_en;
         m_prev = div_clk;
      end
   end

   // per-sample compare and pulse monitor
   int rises = 0;
   int hlen = 0;
   bit last_pad = 1'b0;
   bit run_dropped = 1'b0;
   initial begin
      forever begin
         @(posedge clk);
         #1;
         begin
            bit act, e_data, e_drive;
            act     = m_gate && m_run;
            e_data  = div_clk && act;
            e_drive = act || idle_drive_low;
            chk(pad_data == e_data && pad_drive == e_drive && osc_run == m_run,
                ph, "per-cycle {data,drive,run}",
                {29'd0, pad_data, pad_drive, osc_run}, {29'd0, e_data, e_drive, m_run});
         end
         if (!osc_run) run_dropped = 1'b1;
         if (pad_data && !last_pad) rises++;
         if (pad_data) hlen++;
         if (!pad_data && last_pad) begin
            if (osc_run) chk(hlen == hp, "R9", "pad pulse length", hlen, hp);
            hlen = 0;
         end
         last_pad = pad_data;
      end
   end

   initial begin
      #(100000 * 5);
      errors++;
      checks++;
      $display("FAIL watchdog expired in phase %s: actual=0 expected=1", ph);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int snap;
      // R1 reset state
      cyc(4);
      chk(osc_run == 1'b1, "R1", "osc_run in reset", osc_run, 1);
      chk(pad_data == 1'b0, "R1", "pad_data in reset", pad_data, 0);
      chk(pad_drive == idle_drive_low, "R1", "pad_drive in reset", pad_drive, idle_drive_low);
      rst_n = 1'b1;
      ph = "R2";
      cyc(1);
      chk(pad_data == 1'b0 && osc_run == 1'b1, "R1", "first cycle after reset",
          {pad_data, osc_run}, 1);
      // R2 settling window
      cyc(504);
      chk(rises == 0, "R2", "pulses before settle", rises, 0);
      chk(pad_drive == 1'b1, "R2", "idle drive low during settle", pad_drive, 1);
      ph = "R10";
      cyc(100);
      chk(rises >= 10, "R10", "pulses after settle", rises, 10);
      // R3 output enable low
      ph = "R3";
      out_en = 1'b0;
      cyc(20);
      snap = rises;
      chk(pad_data == 1'b0, "R3", "pad_data with out_en low", pad_data, 0);
      cyc(50);
      chk(rises == snap, "R3", "no pulses with out_en low", rises, snap);
      chk(osc_run == 1'b1, "R3", "osc keeps running", osc_run, 1);
      // R7 idle pad modes
      ph = "R7";
      idle_drive_low = 1'b0;
      cyc(2);
      chk(pad_drive == 1'b0, "R7", "high-Z when idle", pad_drive, 0);
      idle_drive_low = 1'b1;
      cyc(2);
      chk(pad_drive == 1'b1, "R7", "driven low when idle", pad_drive, 1);
      // R8 re-enable with a new half period
      ph = "R8";
      hp = 4;
      cyc(10);
      snap = rises;
      out_en = 1'b1;
      cyc(60);
      chk(rises > snap, "R8", "pulses resume after enable", rises, snap + 1);
      // R4 short power-down request
      ph = "R4";
      run_dropped = 1'b0;
      pwr_on = 1'b0;
      cyc(DG - 10);
      pwr_on = 1'b1;
      cyc(20);
      chk(run_dropped == 1'b0, "R4", "short low ignored", run_dropped, 0);
      // R4 long request but too few divided-clock edges
      out_en = 1'b0;
      hp = 1500;
      cyc(10);
      run_dropped = 1'b0;
      pwr_on = 1'b0;
      cyc(DG + 100);
      pwr_on = 1'b1;
      cyc(5);
      chk(run_dropped == 1'b0, "R4", "slow clock keeps osc", run_dropped, 0);
      hp = 3;
      out_en = 1'b1;
      cyc(40);
      // R5 qualified power-down
      ph = "R5";
      pwr_on = 1'b0;
      cyc(DG + 20);
      chk(osc_run == 1'b0, "R5", "osc stopped", osc_run, 0);
      chk(pad_data == 1'b0 && pad_drive == 1'b1, "R5", "pad low while stopped",
          {pad_data, pad_drive}, 1);
      idle_drive_low = 1'b0;
      cyc(2);
      chk(pad_drive == 1'b0, "R7", "high-Z while stopped", pad_drive, 0);
      idle_drive_low = 1'b1;
      // R6 restart and fresh settling
      ph = "R6";
      pwr_on = 1'b1;
      cyc(1);
      chk(osc_run == 1'b1, "R6", "osc restarts next edge", osc_run, 1);
      snap = rises;
      cyc(500);
      chk(rises == snap, "R6", "no pulses during resettle", rises, snap);
      cyc(60);
      chk(rises > snap, "R6", "pulses after resettle", rises, snap + 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule